// File: doc/BRIEF.md
# Serial Control Port with Line-Status Interrupt

This block is a four-wire serial slave through which a host processor programs a small bank of 8-bit control registers and reads one status register. A transfer takes place while the active-low select is held low. It is clocked by a host-driven shift clock that has no fixed relation to the system clock. The control registers live in the system clock domain and drive the rest of the chip through a flat output bus.

The status register reports the current level of one status flag and one bipolar-violation flag for each of four line channels. Any change in a line status flag sets an interrupt latch, which pulls an open-drain request line low. A change in a violation flag does not set the latch. The latch is released only by a complete serial read of the status register.

A transfer is 16 bits, sent most significant bit first: an 8-bit command byte followed by an 8-bit data byte. Command bit 7 selects a read (1) or a write (0). The low `ADDR_W` bits of the command give the register address, and the other command bits are ignored. Written data and the status-read event are held in the shift-clock domain. They enter the system clock domain through two-flop synchronisers and are committed when the system clock sees the select line rise.

Top module: `mw_ctrl_port`

## Requirements
- R1: After reset every control register holds `CTRL_RST` (0 by default), the interrupt request is released (`irq_pull` = 0) and `cdo_en` is 0.
- R2: A 16-bit frame with command bit 7 = 0 and address A < `NUM_CTRL` loads the data byte into control register A, visible on `ctrl_q[8*A +: 8]` a few system clocks after the select rises.
- R3: While `cs_n` is high, activity on `cclk` and `cdi` changes no register, and `cdo_en` stays 0.
- R4: A frame with command bit 7 = 1 and address A < `NUM_CTRL` shifts control register A out on `cdo` most significant bit first. Each bit changes on a falling edge of `cclk`, and bit 7 is valid before the 9th rising edge. `cdo_en` is 1 through the data phase.
- R5: A read of address `STAT_ADDR` (7 by default) returns the status byte {violation flags[3:0], line status flags[3:0]}, with line 0 in bit 0 of each field.
- R6: Any change in the line status inputs sets the interrupt latch, and `irq_pull` goes to 1.
- R7: A change in the bipolar-violation inputs alone does not set the interrupt latch.
- R8: A set latch stays set through reads of control registers. It clears after a complete read of the status register once the select rises.
- R9: A write to the status address or to an address with no register changes no control register.
- R10: A frame that ends with the select rising before the 16th bit has no effect.
- R11: `cdo_en` stays 0 throughout a write frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select for the serial port |
| cclk | input | 1 | Serial shift clock from the host |
| cdi | input | 1 | Serial data in, sampled on rising `cclk` |
| cdo | output | 1 | Serial data out, changes on falling `cclk` |
| cdo_en | output | 1 | Drive enable for `cdo`; high impedance when 0 |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt line low |
| line_stat | input | NUM_LINES | Per-line status flags |
| line_bpv | input | NUM_LINES | Per-line bipolar-violation flags |
| ctrl_q | output | NUM_CTRL*8 | Control register contents, register 0 in the low byte |

## Verification
The assertions assume that `cclk` is still while the select changes. They also assume that the status and register contents that feed the serial read mux do not change across the falling `cclk` edge that loads the output byte. Finally, they assume that the select stays high long enough for the system clock to see the rise. The bench keeps every shift-clock and select edge two nanoseconds away from any system clock edge. It changes line and violation inputs only while the select is high, and it holds the select high for fifteen system clocks after each frame.

// File: rtl/mw_pkg.sv
package mw_pkg;
   localparam int BYTE_W    = 8;
   localparam int INSTR_LEN = 8;
   localparam int FRAME_LEN = INSTR_LEN + BYTE_W;
   typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam int CHAIN_W = STAGES * W;

   if (STAGES < 2) begin : g_bad_stages
      $error("mw_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[CHAIN_W-W-1:0], d};
   end

   assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/mw_serial_shift.sv
module mw_serial_shift
   import mw_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              cclk,
   input  logic              cdi,
   input  byte_t             rd_byte,
   output logic              cdo,
   output logic              cdo_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              xf_tgl,
   output logic              xf_wr,
   output logic [ADDR_W-1:0] xf_addr,
   output byte_t             xf_data
);
   localparam int CNT_W = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_INS_LAST = CNT_W'(INSTR_LEN - 1);
   localparam logic [CNT_W-1:0] CNT_DAT_FIRST = CNT_W'(INSTR_LEN);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_LEN);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);

   logic             ser_rst;
   logic [CNT_W-1:0] cnt;
   logic [BYTE_W-2:0] in_sr;
   logic             ins_rd;
   logic [ADDR_W-1:0] ins_addr;
   byte_t            out_sr;
   logic             en_q;

   assign ser_rst = cs_n | ~rst_n;

   // bit counter, cleared whenever the select is high
   always_ff @(posedge cclk or posedge ser_rst) begin
      if (ser_rst)             cnt <= '0;
      else if (cnt != CNT_END) cnt <= cnt + 1'b1;
   end

   // input shifting, command capture and transfer capture
   always_ff @(posedge cclk or negedge rst_n) begin
      if (!rst_n) begin
         in_sr    <= '0;
         ins_rd   <= 1'b0;
         ins_addr <= '0;
         xf_tgl   <= 1'b0;
         xf_wr    <= 1'b0;
         xf_addr  <= '0;
         xf_data  <= '0;
      end else begin
         if (cnt < CNT_END) in_sr <= {in_sr[BYTE_W-3:0], cdi};
         if (cnt == CNT_INS_LAST) begin
            ins_rd   <= in_sr[INSTR_LEN-2];
            ins_addr <= {in_sr[ADDR_W-2:0], cdi};
         end
         if (cnt == CNT_LAST) begin
            xf_tgl  <= ~xf_tgl;
            xf_wr   <= ~ins_rd;
            xf_addr <= ins_addr;
            xf_data <= {in_sr, cdi};
         end
      end
   end

   // output shifting on the falling edge
   always_ff @(negedge cclk or posedge ser_rst) begin
      if (ser_rst) begin
         out_sr <= '0;
         en_q   <= 1'b0;
      end else if (cnt == CNT_DAT_FIRST) begin
         out_sr <= rd_byte;
         en_q   <= ins_rd;
      end else if (cnt > CNT_DAT_FIRST && cnt < CNT_END) begin
         out_sr <= {out_sr[BYTE_W-2:0], 1'b0};
      end else if (cnt == CNT_END) begin
         en_q <= 1'b0;
      end
   end

   assign cdo     = out_sr[BYTE_W-1];
   assign cdo_en  = en_q;
   assign rd_addr = ins_addr;

   // R11
   cdo_rd_only_chk: assert property (@(posedge cclk) disable iff (ser_rst)
      en_q |-> ins_rd)
      else $error("cdo driven outside a read frame");
endmodule

// File: rtl/mw_regbank.sv
module mw_regbank
   import mw_pkg::*;
#(
   parameter int    NUM_CTRL  = 4,
   parameter int    ADDR_W    = 3,
   parameter int    STAT_ADDR = 7,
   parameter byte_t CTRL_RST  = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_s,
   input  logic                       xf_tgl,
   input  logic                       xf_wr,
   input  logic [ADDR_W-1:0]          xf_addr,
   input  byte_t                      xf_data,
   output logic [NUM_CTRL*BYTE_W-1:0] ctrl_flat,
   output logic                       stat_clr
);
   logic cs_d;
   logic tgl_seen;
   logic cs_rise;
   logic commit;

   assign cs_rise  = cs_s & ~cs_d;
   assign commit   = cs_rise & (xf_tgl ^ tgl_seen);
   assign stat_clr = commit & ~xf_wr & (xf_addr == ADDR_W'(STAT_ADDR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d     <= 1'b1;
         tgl_seen <= 1'b0;
      end else begin
         cs_d <= cs_s;
         if (cs_rise) tgl_seen <= xf_tgl;
      end
   end

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
      byte_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= CTRL_RST;
         else if (commit && xf_wr && xf_addr == ADDR_W'(g))
            q <= xf_data;
      end
      assign ctrl_flat[g*BYTE_W +: BYTE_W] = q;
   end

   // R2
   ctrl_on_select_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> $stable(ctrl_flat))
      else $error("control register changed away from a select rise");
endmodule

// File: rtl/mw_irq.sv
module mw_irq
   import mw_pkg::*;
#(
   parameter int NUM_LINES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] line_raw,
   input  logic [NUM_LINES-1:0] bpv_raw,
   input  logic                 clr,
   output logic                 irq,
   output byte_t                stat_byte
);
   localparam int STAT_USED = 2 * NUM_LINES;

   logic [NUM_LINES-1:0] line_s;
   logic [NUM_LINES-1:0] bpv_s;
   logic [NUM_LINES-1:0] line_prev;
   logic                 chg;
   logic                 irq_q;

   mw_sync #(.W(NUM_LINES), .STAGES(2)) line_sync_i (
      .clk(clk), .rst_n(rst_n), .d(line_raw), .q(line_s));
   mw_sync #(.W(NUM_LINES), .STAGES(2)) bpv_sync_i (
      .clk(clk), .rst_n(rst_n), .d(bpv_raw), .q(bpv_s));

   assign chg = |(line_s ^ line_prev);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_prev <= '0;
         irq_q     <= 1'b0;
      end else begin
         line_prev <= line_s;
         if (chg)      irq_q <= 1'b1;
         else if (clr) irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

   if (STAT_USED < BYTE_W) begin : g_pad
      assign stat_byte = {{(BYTE_W-STAT_USED){1'b0}}, bpv_s, line_s};
   end else begin : g_full
      assign stat_byte = {bpv_s, line_s};
   end

   // R6
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> irq_q)
      else $error("line change did not set interrupt");
   // R8
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr) |=> irq_q)
      else $error("interrupt dropped without status read");
   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> $past(chg))
      else $error("interrupt set without a line change");
endmodule

// File: rtl/mw_ctrl_port.sv
module mw_ctrl_port
   import mw_pkg::*;
#(
   parameter int    NUM_CTRL  = 4,
   parameter int    ADDR_W    = 3,
   parameter int    STAT_ADDR = 7,
   parameter int    NUM_LINES = 4,
   parameter byte_t CTRL_RST  = '0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cs_n,
   input  logic                       cclk,
   input  logic                       cdi,
   output logic                       cdo,
   output logic                       cdo_en,
   output logic                       irq_pull,
   input  logic [NUM_LINES-1:0]       line_stat,
   input  logic [NUM_LINES-1:0]       line_bpv,
   output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q
);
   localparam int XF_W = 2 + ADDR_W + BYTE_W;

   if (ADDR_W < 2 || ADDR_W > INSTR_LEN - 1) begin : g_bad_addr
      $error("mw_ctrl_port: ADDR_W out of range");
   end
   if (NUM_CTRL < 1 || NUM_CTRL > (1 << ADDR_W)) begin : g_bad_ctrl
      $error("mw_ctrl_port: NUM_CTRL does not fit the address field");
   end
   if (STAT_ADDR < NUM_CTRL || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_stat
      $error("mw_ctrl_port: STAT_ADDR collides or does not fit");
   end
   if (2 * NUM_LINES > BYTE_W) begin : g_bad_lines
      $error("mw_ctrl_port: status byte cannot hold all lines");
   end

   logic              xf_tgl, xf_wr;
   logic [ADDR_W-1:0] xf_addr;
   byte_t             xf_data;
   logic [XF_W-1:0]   xf_s;
   logic              cs_s;
   logic [ADDR_W-1:0] rd_addr;
   byte_t             rd_byte;
   byte_t             stat_byte;
   logic              stat_clr;

   mw_serial_shift #(.ADDR_W(ADDR_W)) shift_i (
      .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk), .cdi(cdi), .rd_byte(rd_byte),
      .cdo(cdo), .cdo_en(cdo_en), .rd_addr(rd_addr),
      .xf_tgl(xf_tgl), .xf_wr(xf_wr), .xf_addr(xf_addr), .xf_data(xf_data));

   mw_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) cs_sync_i (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));

   mw_sync #(.W(XF_W), .STAGES(2)) xf_sync_i (
      .clk(clk), .rst_n(rst_n), .d({xf_tgl, xf_wr, xf_addr, xf_data}), .q(xf_s));

   mw_regbank #(.NUM_CTRL(NUM_CTRL), .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR),
                .CTRL_RST(CTRL_RST)) bank_i (
      .clk(clk), .rst_n(rst_n), .cs_s(cs_s),
      .xf_tgl(xf_s[XF_W-1]), .xf_wr(xf_s[XF_W-2]),
      .xf_addr(xf_s[BYTE_W +: ADDR_W]), .xf_data(xf_s[BYTE_W-1:0]),
      .ctrl_flat(ctrl_q), .stat_clr(stat_clr));

   mw_irq #(.NUM_LINES(NUM_LINES)) irq_i (
      .clk(clk), .rst_n(rst_n), .line_raw(line_stat), .bpv_raw(line_bpv),
      .clr(stat_clr), .irq(irq_pull), .stat_byte(stat_byte));

   always_comb begin
      rd_byte = '0;
      for (int g = 0; g < NUM_CTRL; g++)
         if (rd_addr == ADDR_W'(g)) rd_byte = ctrl_q[g*BYTE_W +: BYTE_W];
      if (rd_addr == ADDR_W'(STAT_ADDR)) rd_byte = stat_byte;
   end

   // R3
   cdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !cdo_en)
      else $error("cdo driven while deselected");
endmodule

// File: tb/mw_ctrl_port_tb.sv
module mw_ctrl_port_tb_top;
   localparam int CLK_PER = 10;
   localparam int NC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic cclk = 1'b0;
   logic cdi = 1'b0;
   logic cdo, cdo_en, irq_pull;
   logic [3:0] line_stat = '0;
   logic [3:0] line_bpv = '0;
   logic [NC*8-1:0] ctrl_q;

   int total = 0;
   int bad = 0;
   logic [7:0] model [NC];

   always #(CLK_PER/2) clk = ~clk;

   mw_ctrl_port dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cclk(cclk), .cdi(cdi),
      .cdo(cdo), .cdo_en(cdo_en), .irq_pull(irq_pull),
      .line_stat(line_stat), .line_bpv(line_bpv), .ctrl_q(ctrl_q));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic frame(input logic [7:0] ins, input logic [7:0] dat, input int nbits,
                        output logic [7:0] rd, output logic [7:0] enm);
      logic [15:0] w;
      w = {ins, dat};
      rd = '0;
      enm = '0;
      cs_n = 1'b0;
      #20;
      for (int i = 0; i < nbits; i++) begin
         cdi = w[15-i];
         #40;
         if (i >= 8) begin
            rd[15-i]  = cdo;
            enm[15-i] = cdo_en;
         end
         cclk = 1'b1;
         #50;
         cclk = 1'b0;
         #10;
      end
      #20;
      cs_n = 1'b1;
      #150;
   endtask

   task automatic check_bank(input string req);
      for (int r = 0; r < NC; r++) chk(req, 32'(ctrl_q[r*8 +: 8]), 32'(model[r]));
   endtask

   initial begin
      #1_500_000;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] rd, enm;
      #2;
      #50;
      rst_n = 1'b1;
      #30;
      for (int r = 0; r < NC; r++) model[r] = 8'h00;
      // R1 reset state
      chk("R1 irq", 32'(irq_pull), 0);
      chk("R1 cdo_en", 32'(cdo_en), 0);
      check_bank("R1 ctrl");

      // R2, R4, R11 sweep over registers and patterns
      for (int k = 0; k < 6; k++) begin
         for (int r = 0; r < NC; r++) begin
            logic [7:0] pat;
            pat = 8'((k*73 + r*29 + 5) ^ 8'hC3);
            frame({5'b0, 3'(r)}, pat, 16, rd, enm);
            model[r] = pat;
            chk("R11 write enable", 32'(enm), 0);
            chk("R2 write", 32'(ctrl_q[r*8 +: 8]), 32'(pat));
         end
         for (int r = 0; r < NC; r++) begin
            frame({1'b1, 4'b0, 3'(r)}, 8'h00, 16, rd, enm);
            chk("R4 readback", 32'(rd), 32'(model[r]));
            chk("R4 enable", 32'(enm), 32'hFF);
         end
      end

      // R9 writes to the status address and an empty address
      frame(8'h07, 8'hEE, 16, rd, enm);
      check_bank("R9 status addr");
      frame(8'h05, 8'h77, 16, rd, enm);
      check_bank("R9 empty addr");

      // R3 clocking while deselected
      for (int i = 0; i < 16; i++) begin
         cdi = i[0];
         #40;
         cclk = 1'b1;
         #10;
         chk("R3 cdo_en", 32'(cdo_en), 0);
         #40;
         cclk = 1'b0;
         #10;
      end
      #150;
      check_bank("R3 ctrl");

      // R10 aborted write
      frame(8'h01, 8'h3C, 12, rd, enm);
      check_bank("R10 abort");
      frame(8'h02, 8'hC3, 15, rd, enm);
      check_bank("R10 abort");

      // R5, R6, R8 line status sweep
      for (int v = 1; v < 16; v++) begin
         line_stat = 4'(v);
         #100;
         chk("R6 irq set", 32'(irq_pull), 1);
         if (v == 1 || v == 9) begin
            frame(8'h80, 8'h00, 16, rd, enm);
            chk("R8 held by ctrl read", 32'(irq_pull), 1);
         end
         frame(8'h87, 8'h00, 16, rd, enm);
         chk("R5 status", 32'(rd), 32'({4'h0, 4'(v)}));
         chk("R8 cleared", 32'(irq_pull), 0);
      end

      // R7 violation sweep
      for (int b = 1; b < 16; b++) begin
         line_bpv = 4'(b);
         #100;
         chk("R7 no irq", 32'(irq_pull), 0);
         frame(8'h87, 8'h00, 16, rd, enm);
         chk("R5 status bpv", 32'(rd), 32'({4'(b), 4'hF}));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule